// File: doc/BRIEF.md
# Gated Serial Clock Divider Controller

This block derives the serial-interface clock from the system clock. A 2-bit divide selector sets the half-period to 1, 2, 4 or 8 system cycles, so the serial clock period is twice that. A phase selector places a one-cycle launch strobe inside each period: either at the falling edge of the serial clock (180-degree setting) or a quarter period after the rising edge (90-degree setting). Divide and phase are captured only when the clock is switched on. While the clock runs, changes on those inputs are ignored.

The clock runs only while two enable inputs, a boot-time one and a normal one, are both high. When either enable drops, the block waits for the transfer engine to report idle and for the current low half-period to finish. It then parks the clock low and holds the divider counter in reset. A clock-stopped status follows two system cycles later. An idle status combines the transfer engine's idle flag with the bus read and write busy flags. A configuration-safe output tells software when both the idle status and the clock-stopped status are set.

Top module: `gclk_ctrl`

## Requirements
- R1: With divide selector d (0 = /1, 1 = /2, 2 = /4, 3 = /8), let N = 2^d. While running, `ser_clk` has a period of 2·N system cycles. It is high for the first N cycles of each period. Its first high cycle is the cycle right after the clock edge that accepts the enable.
- R2: `launch_stb` pulses for one cycle in every period. With `phase90` = 0 (180 degrees) the pulse falls N cycles after the rising edge, which is the falling edge. With `phase90` = 1 (90 degrees) it falls floor(N/2) cycles after the rising edge, so for N = 1 it coincides with the rising edge.
- R3: The clock starts only when `en_boot` and `en_run` are both 1. With either one at 0 and the clock stopped, `ser_clk` stays 0 and `clk_stopped` stays 1.
- R4: A stop request never shortens a pulse. After the enable drops, the current high half and the following low half both complete in full. The clock then remains at 0.
- R5: The clock is not stopped while `xfer_idle` is 0. It keeps toggling until `xfer_idle` is 1. The stop then happens at the end of the next low half.
- R6: The divide and phase values are captured at the enable edge. Changing `div_sel` or `phase90` while running has no effect on `ser_clk` or `launch_stb`.
- R7: `clk_stopped` rises on the second clock edge after the edge that stops the clock. It falls on the same edge that accepts a new enable.
- R8: `if_idle` equals `xfer_idle` AND NOT `bus_rd_busy` AND NOT `bus_wr_busy`, registered with one cycle of latency.
- R9: `cfg_ok` is 1 exactly when `if_idle` and `clk_stopped` are both 1.
- R10: Synchronous reset puts the block in the stopped state. After reset, `ser_clk` = 0, `launch_stb` = 0, `clk_stopped` = 1, `if_idle` = 0 and `cfg_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_boot | input | 1 | Boot-time clock enable |
| en_run | input | 1 | Normal clock enable |
| div_sel | input | 2 | Divide selector, half-period 2^div_sel cycles |
| phase90 | input | 1 | 0 = strobe at 180 degrees, 1 = strobe at 90 degrees |
| xfer_idle | input | 1 | Transfer engine reports idle |
| bus_rd_busy | input | 1 | Bus slave read in progress |
| bus_wr_busy | input | 1 | Bus slave write in progress |
| ser_clk | output | 1 | Divided, gated serial clock |
| launch_stb | output | 1 | One-cycle phase strobe per serial period |
| clk_stopped | output | 1 | Clock has halted |
| if_idle | output | 1 | Registered interface idle status |
| cfg_ok | output | 1 | Safe to change configuration |

## Verification
The assertions rely on four assumptions about the inputs:
- Reset is synchronous and is held for at least one edge.
- The enables and `xfer_idle` are sampled only at rising edges.
- `div_sel` and `phase90` can change at any time, so freezing them is the design's job rather than something the environment supplies.
- No assertion assumes `xfer_idle` eventually rises.

The bench drives every input on the falling edge, which keeps all stimulus clear of the sampling edge. It lowers the enables only at known counter positions, so each expected stop edge can be computed in advance. It deliberately holds `xfer_idle` low across several periods, and changes the divide and phase inputs in mid-run, to probe the stop and capture rules.

// File: rtl/gclk_pkg.sv
package gclk_pkg;

    localparam int DIV_SEL_W = 2;
    // the longest period is 2 * 2^(2^DIV_SEL_W - 1) = 2^(2^DIV_SEL_W)
    localparam int CNT_W     = 1 << DIV_SEL_W;

    typedef logic [DIV_SEL_W-1:0] div_sel_t;
    typedef logic [CNT_W-1:0]     cnt_t;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;

    typedef struct packed {
        div_sel_t div;
        logic     ph90;
    } clk_cfg_t;

    // number of system cycles in one half of the serial clock
    function automatic cnt_t half_len(div_sel_t d);
        return cnt_t'(1) << d;
    endfunction

    // final count value of a full serial period (wraps cleanly at the top)
    function automatic cnt_t last_cnt(div_sel_t d);
        return (half_len(d) << 1) - cnt_t'(1);
    endfunction

    // count position of the launch strobe
    function automatic cnt_t strobe_pt(clk_cfg_t c);
        return c.ph90 ? (half_len(c.div) >> 1) : half_len(c.div);
    endfunction

endpackage

// File: rtl/gclk_gate_fsm.sv
module gclk_gate_fsm
    import gclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_req,
    input  logic     xfer_idle,
    input  logic     cnt_last,
    input  clk_cfg_t cfg_in,
    output logic     gate_on,
    output logic     gate_start,
    output clk_cfg_t cfg_q
);

    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: if (run_req) state_d = GATE_ON;
            GATE_ON:  if (!run_req && xfer_idle && cnt_last) state_d = GATE_OFF;
        endcase
    end

    assign gate_on    = (state_q == GATE_ON);
    assign gate_start = (state_q == GATE_OFF) && run_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_OFF;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (gate_start) begin
                cfg_q <= cfg_in;
            end
        end
    end

    // captured setting must not move while the clock keeps running
    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (gate_on && $past(gate_on)) |-> $stable(cfg_q));

    // a stop only happens with the engine idle and no enable pending
    assert_stop_waits_idle_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_on) |-> ($past(xfer_idle) && !$past(run_req)));

endmodule

// File: rtl/gclk_div_core.sv
module gclk_div_core
    import gclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     gate_on,
    input  clk_cfg_t cfg,
    output logic     ser_clk,
    output logic     launch_stb,
    output logic     cnt_last
);

    cnt_t cnt_q;

    assign cnt_last   = gate_on && (cnt_q == last_cnt(cfg.div));
    assign ser_clk    = gate_on && (cnt_q < half_len(cfg.div));
    assign launch_stb = gate_on && (cnt_q == strobe_pt(cfg));

    // the counter sits at zero whenever the gate is closed
    always_ff @(posedge clk) begin
        if (rst || !gate_on) begin
            cnt_q <= '0;
        end else if (cnt_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end

    assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (rst)
        gate_on |-> (cnt_q <= last_cnt(cfg.div)));

    // closing the gate must follow a low cycle, never cut a high one
    assert_no_runt_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_on) |-> !$past(ser_clk));

endmodule

// File: rtl/gclk_status.sv
module gclk_status (
    input  logic clk,
    input  logic rst,
    input  logic gate_on,
    input  logic gate_start,
    input  logic xfer_idle,
    input  logic bus_rd_busy,
    input  logic bus_wr_busy,
    output logic clk_stopped,
    output logic if_idle,
    output logic cfg_ok
);

    logic off_d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_d1      <= 1'b1;
            clk_stopped <= 1'b1;
            if_idle     <= 1'b0;
        end else begin
            off_d1      <= !gate_on && !gate_start;
            clk_stopped <= !gate_on && !gate_start && off_d1;
            if_idle     <= xfer_idle && !bus_rd_busy && !bus_wr_busy;
        end
    end

    assign cfg_ok = if_idle && clk_stopped;

    assert_stopped_excl_run_R7: assert property (@(posedge clk) disable iff (rst)
        clk_stopped |-> !gate_on);

    assert_stop_delay_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_stopped) |-> (!$past(gate_on) && !$past(gate_on, 2)));

endmodule

// File: rtl/gclk_ctrl.sv
module gclk_ctrl
    import gclk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_boot,
    input  logic                 en_run,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 phase90,
    input  logic                 xfer_idle,
    input  logic                 bus_rd_busy,
    input  logic                 bus_wr_busy,
    output logic                 ser_clk,
    output logic                 launch_stb,
    output logic                 clk_stopped,
    output logic                 if_idle,
    output logic                 cfg_ok
);

    clk_cfg_t cfg_in, cfg_q;
    logic     gate_on, gate_start, cnt_last;

    assign cfg_in = '{div: div_sel, ph90: phase90};

    gclk_gate_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .run_req    (en_boot && en_run),
        .xfer_idle  (xfer_idle),
        .cnt_last   (cnt_last),
        .cfg_in     (cfg_in),
        .gate_on    (gate_on),
        .gate_start (gate_start),
        .cfg_q      (cfg_q)
    );

    gclk_div_core u_core (
        .clk        (clk),
        .rst        (rst),
        .gate_on    (gate_on),
        .cfg        (cfg_q),
        .ser_clk    (ser_clk),
        .launch_stb (launch_stb),
        .cnt_last   (cnt_last)
    );

    gclk_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .gate_on     (gate_on),
        .gate_start  (gate_start),
        .xfer_idle   (xfer_idle),
        .bus_rd_busy (bus_rd_busy),
        .bus_wr_busy (bus_wr_busy),
        .clk_stopped (clk_stopped),
        .if_idle     (if_idle),
        .cfg_ok      (cfg_ok)
    );

    // the clock may only start with both enables present
    assert_start_needs_both_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_on) |-> ($past(en_boot) && $past(en_run)));

    assert_cfg_ok_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_ok |-> (clk_stopped && !ser_clk));

endmodule

// File: tb/test_gclk_ctrl.sv
module test_gclk_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       en_boot, en_run, phase90, xfer_idle, bus_rd_busy, bus_wr_busy;
    logic [1:0] div_sel;
    logic       ser_clk, launch_stb, clk_stopped, if_idle, cfg_ok;

    int n_tot  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    gclk_ctrl i_gclk_ctrl (
        .clk(clk), .rst(rst), .en_boot(en_boot), .en_run(en_run),
        .div_sel(div_sel), .phase90(phase90), .xfer_idle(xfer_idle),
        .bus_rd_busy(bus_rd_busy), .bus_wr_busy(bus_wr_busy),
        .ser_clk(ser_clk), .launch_stb(launch_stb), .clk_stopped(clk_stopped),
        .if_idle(if_idle), .cfg_ok(cfg_ok)
    );

    // {div_sel, phase90}
    localparam logic [2:0] VEC_TBL [0:7] = '{
        3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tot++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R1/R2: walk two periods, then stop at end of period and time the status (R7)
    task automatic run_vec(input logic [1:0] d, input logic ph);
        int n, off, bad_clk, bad_stb, st0, st1, st2, clk0;
        n = 1 << d;
        off = ph ? (n / 2) : n;
        bad_clk = 0;
        bad_stb = 0;
        @(negedge clk);
        div_sel = d; phase90 = ph; en_boot = 1'b1; en_run = 1'b1;
        for (int k = 0; k < 4 * n; k++) begin
            @(negedge clk);
            if (ser_clk !== ((k % (2 * n)) < n)) bad_clk++;
            if (launch_stb !== ((k % (2 * n)) == off)) bad_stb++;
        end
        chk($sformatf("R1 div=%0d ph=%0d clk mismatches", d, ph), bad_clk, 0);
        chk($sformatf("R2 div=%0d ph=%0d strobe mismatches", d, ph), bad_stb, 0);
        en_run = 1'b0;   // counter now at last value -> stops on next edge
        @(negedge clk); clk0 = ser_clk; st0 = clk_stopped;
        @(negedge clk); st1 = clk_stopped;
        @(negedge clk); st2 = clk_stopped;
        chk("R7 stopped timing {clk,s0,s1,s2}", {clk0, st0, st1, st2}, 4'b0001);
    endtask

    initial begin
        int bad, highs, waitn;
        rst = 1'b1; en_boot = 1'b0; en_run = 1'b0; div_sel = 2'd0; phase90 = 1'b0;
        xfer_idle = 1'b1; bus_rd_busy = 1'b0; bus_wr_busy = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset {ser_clk,stb,stopped,idle,cfg_ok}",
            {ser_clk, launch_stb, clk_stopped, if_idle, cfg_ok}, 5'b00100);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 after release clk_stopped", clk_stopped, 1);

        for (int v = 0; v < 8; v++) begin
            run_vec(VEC_TBL[v][2:1], VEC_TBL[v][0]);
        end

        // R3: one enable alone does nothing
        bad = 0;
        en_boot = 1'b1; en_run = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (ser_clk !== 1'b0 || clk_stopped !== 1'b1) bad++;
        end
        chk("R3 boot enable only", bad, 0);
        bad = 0;
        en_boot = 1'b0; en_run = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (ser_clk !== 1'b0 || clk_stopped !== 1'b1) bad++;
        end
        chk("R3 run enable only", bad, 0);
        en_run = 1'b0;

        // R4: drop enable during first high cycle, N = 4
        bad = 0;
        @(negedge clk);
        div_sel = 2'd2; phase90 = 1'b0; en_boot = 1'b1; en_run = 1'b1;
        @(negedge clk);                    // k = 0
        en_run = 1'b0;
        for (int k = 1; k < 11; k++) begin
            @(negedge clk);
            if (ser_clk !== (k < 4)) bad++;
            if (clk_stopped !== (k >= 10)) bad++;
        end
        chk("R4 full halves before stop", bad, 0);

        // R5: stop held off by busy engine, N = 2
        highs = 0;
        @(negedge clk);
        div_sel = 2'd1; en_run = 1'b1; xfer_idle = 1'b0;
        @(negedge clk);                    // k = 0
        en_run = 1'b0; en_boot = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (ser_clk === 1'b1) highs++;
        end
        chk("R5 keeps toggling while busy (high cycles)", highs, 6);
        chk("R5 not stopped while busy", clk_stopped, 0);
        xfer_idle = 1'b1;                  // counter at 0 now
        waitn = 0;
        while (clk_stopped !== 1'b1 && waitn < 40) begin
            @(negedge clk);
            waitn++;
        end
        chk("R5 cycles from idle to stopped", waitn, 6);

        // R6: settings changed mid-run are ignored
        bad = 0;
        @(negedge clk);
        div_sel = 2'd0; phase90 = 1'b0; en_boot = 1'b1; en_run = 1'b1;
        @(negedge clk);                    // k = 0
        chk("R9 cfg_ok low while running", cfg_ok, 0);
        div_sel = 2'd3; phase90 = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (ser_clk !== ((k % 2) == 0)) bad++;
            if (launch_stb !== ((k % 2) == 1)) bad++;
        end
        chk("R6 captured setting kept", bad, 0);
        en_run = 1'b0;
        waitn = 0;
        while (clk_stopped !== 1'b1 && waitn < 40) begin
            @(negedge clk);
            waitn++;
        end
        chk("R6 stop after frozen /1 period", waitn, 4);

        // R8/R9: idle status combination while stopped
        en_boot = 1'b0;
        bus_rd_busy = 1'b1;
        @(negedge clk);
        chk("R8 read busy -> idle low", if_idle, 0);
        chk("R9 cfg_ok low with read busy", cfg_ok, 0);
        bus_rd_busy = 1'b0;
        @(negedge clk);
        chk("R8 all quiet -> idle high", if_idle, 1);
        chk("R9 cfg_ok high", cfg_ok, 1);
        bus_wr_busy = 1'b1;
        @(negedge clk);
        chk("R8 write busy -> idle low", if_idle, 0);
        bus_wr_busy = 1'b0; xfer_idle = 1'b0;
        @(negedge clk);
        chk("R8 engine busy -> idle low", if_idle, 0);
        xfer_idle = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tot++;
        n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

endmodule